// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block drives the reset line of a microcontroller from three causes: a supply-good flag from an external comparator, an active-low manual reset pin, and a watchdog that expects the host to toggle a kick pin at regular intervals. Any active cause asserts the reset output. When every cause has cleared, the output is held for a fixed recovery period before it is released.

The supply-good, manual and kick pins are asynchronous, and each passes through a two-flop synchronizer. The kick pin also passes through a glitch filter, so a level change counts only if it stays stable for a set number of cycles. Either direction of an accepted change restarts the watchdog. A watchdog timeout goes back through the recovery stretcher, and the watchdog count stays at zero while reset is asserted. As a result, a kick pin stuck at one level gives a steady train of reset pulses.

The watchdog-enable input is synchronous. While it is low, the watchdog does not count. All durations are parameters counted in clock cycles, and a parameter selects the output polarity.

Top module: `rst_supervisor`

## Requirements
- R1: While `pwr_ok_i` is low (supply below threshold), reset is asserted from the third rising clock edge after the fall onward.
- R2: While `man_rst_ni` is low, reset is asserted from the third rising clock edge after the fall onward.
- R3: After the last active source clears, reset is released on rising edge REC_CYC+2 counted from the pin change: two synchronizer cycles, then REC_CYC cycles of recovery.
- R4: If the supply dips again during the recovery window, the recovery count starts over, and release comes REC_CYC+2 edges after the final rise.
- R5: Reset is asserted while `rst_ni` is low. After `rst_ni` goes high with good inputs, reset is released on the REC_CYC+2-th rising edge.
- R6: With the watchdog enabled and no accepted kick, reset asserts on rising edge WD_CYC counted from the point where counting began (a release of reset, or the rise of `wd_en_i`). It is then held for exactly REC_CYC cycles.
- R7: The watchdog does not count while reset is asserted. With the kick pin held at one level, reset is repeatedly deasserted for exactly WD_CYC cycles and asserted for exactly REC_CYC cycles.
- R8: A kick level change of either direction that is held for at least FILT_CYC cycles restarts the watchdog. Kicks spaced below the timeout keep reset released. After the last kick, reset asserts WD_CYC+FILT_CYC+3 edges after the pin change.
- R9: Kick pulses shorter than FILT_CYC cycles have no effect on the watchdog timeout.
- R10: While `wd_en_i` is low, the watchdog never causes reset.
- R11: With ACT_LOW=1, reset asserted drives `rst_o` to 0. With ACT_LOW=0, reset asserted drives it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| pwr_ok_i | input | 1 | Supply-good flag from comparator, asynchronous, 1 = above threshold |
| man_rst_ni | input | 1 | Manual reset, asynchronous, active low |
| wd_kick_i | input | 1 | Watchdog kick, asynchronous; either edge kicks |
| wd_en_i | input | 1 | Synchronous watchdog enable |
| rst_o | output | 1 | Reset output, polarity set by ACT_LOW |

## Verification
Supply and manual pulses have random widths, and supply dips fall at random points inside the recovery window. Together these separate a stretcher that restarts its count from one that resumes it or that is measured from the wrong edge. Three kick patterns are used on the watchdog. Sub-threshold glitches must leave the timeout exactly WD_CYC. A stuck pin must give exact WD_CYC/REC_CYC low/high lengths, which exposes an off-by-one in the freeze or in the feedback. Randomly spaced full toggles must hold off reset and then time out at the exact filter-plus-timeout latency. An active-high twin instance runs in parallel and must mirror the active-low one on every cycle.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  function automatic int unsigned cnt_w(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= {W{RST_VAL}};
      q_o    <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/rsv_kick_filter.sv
module rsv_kick_filter
  import rsv_pkg::*;
#(
  parameter int unsigned FILT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic tog_o
);
  localparam int unsigned FW = cnt_w(FILT_CYC);
  localparam logic [FW-1:0] FLAST = FW'(FILT_CYC - 1);

  logic          lvl_q;
  logic [FW-1:0] cnt_q;

  // accept a new level only after FILT_CYC stable cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
      tog_o <= 1'b0;
    end else begin
      tog_o <= 1'b0;
      if (kick_i == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == FLAST) begin
        lvl_q <= kick_i;
        cnt_q <= '0;
        tog_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rsv_wdog.sv
module rsv_wdog
  import rsv_pkg::*;
#(
  parameter int unsigned WD_CYC = 1600
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      en_i,
  input  logic                      hold_i,
  input  logic                      kick_i,
  output logic                      fire_o,
  output logic [cnt_w(WD_CYC)-1:0]  cnt_o
);
  localparam int unsigned WW = cnt_w(WD_CYC);
  localparam logic [WW-1:0] WLAST = WW'(WD_CYC - 1);

  assign fire_o = en_i && !hold_i && !kick_i && (cnt_o == WLAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 cnt_o <= '0;
    else if (hold_i || !en_i || kick_i || fire_o) cnt_o <= '0;
    else                                         cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rsv_stretch.sv
module rsv_stretch
  import rsv_pkg::*;
#(
  parameter int unsigned REC_CYC = 200
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      src_i,
  output logic                      act_o,
  output logic [cnt_w(REC_CYC)-1:0] cnt_o
);
  localparam int unsigned RW = cnt_w(REC_CYC);
  localparam logic [RW-1:0] RLAST = RW'(REC_CYC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b1;
      cnt_o <= '0;
    end else if (src_i) begin
      act_o <= 1'b1;
      cnt_o <= '0;
    end else if (act_o) begin
      if (cnt_o == RLAST) begin
        act_o <= 1'b0;
        cnt_o <= '0;
      end else begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsv_pkg::*;
#(
  parameter int unsigned REC_CYC  = 200,
  parameter int unsigned WD_CYC   = 1600,
  parameter int unsigned FILT_CYC = 4,
  parameter bit          ACT_LOW  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  input  logic man_rst_ni,
  input  logic wd_kick_i,
  input  logic wd_en_i,
  output logic rst_o
);
  localparam int unsigned WW = cnt_w(WD_CYC);
  localparam int unsigned RW = cnt_w(REC_CYC);

  logic [2:0]    pin_s;
  logic          kick_tog;
  logic          wd_fire;
  logic          src_act;
  logic          rst_act;
  logic [WW-1:0] wd_cnt;
  logic [RW-1:0] rec_cnt;

  // synchronizers reset to "bad" so reset holds until inputs are seen
  rsv_sync #(.W(3), .RST_VAL(1'b0)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({wd_kick_i, man_rst_ni, pwr_ok_i}),
    .q_o    (pin_s)
  );

  rsv_kick_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (pin_s[2]),
    .tog_o  (kick_tog)
  );

  rsv_wdog #(.WD_CYC(WD_CYC)) u_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (wd_en_i),
    .hold_i (rst_act),
    .kick_i (kick_tog),
    .fire_o (wd_fire),
    .cnt_o  (wd_cnt)
  );

  assign src_act = !pin_s[0] || !pin_s[1] || wd_fire;

  rsv_stretch #(.REC_CYC(REC_CYC)) u_strch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_act),
    .act_o  (rst_act),
    .cnt_o  (rec_cnt)
  );

  generate
    if (ACT_LOW) begin : g_lo
      assign rst_o = !rst_act;
    end else begin : g_hi
      assign rst_o = rst_act;
    end
  endgenerate
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
  parameter int unsigned WW      = 1,
  parameter int unsigned RW      = 1,
  parameter int unsigned REC_CYC = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wd_en_i,
  input logic          src_act,
  input logic          rst_act,
  input logic          wd_fire,
  input logic [WW-1:0] wd_cnt,
  input logic [RW-1:0] rec_cnt
);
  a_r1_src_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_act |=> rst_act);

  a_r3_full_recovery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_act) |-> ($past(rec_cnt) == RW'(REC_CYC - 1)) && !$past(src_act));

  a_r6_fire_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_fire |=> rst_act);

  a_r7_wd_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_act && $past(rst_act)) |-> (wd_cnt == '0));

  a_r10_wd_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en_i |=> (wd_cnt == '0) && !wd_fire);
endmodule

bind rst_supervisor rsv_checker #(
  .WW(WW), .RW(RW), .REC_CYC(REC_CYC)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wd_en_i (wd_en_i),
  .src_act (src_act),
  .rst_act (rst_act),
  .wd_fire (wd_fire),
  .wd_cnt  (wd_cnt),
  .rec_cnt (rec_cnt)
);

// File: tb/sim_rst_supervisor.sv
module sim_rst_supervisor;
  localparam int REC  = 20;
  localparam int WD   = 100;
  localparam int FILT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b1, man_n = 1'b1, kick = 1'b0, wd_en = 1'b0;
  logic rst_lo, rst_hi;
  int   total = 0, bad = 0, pol_bad = 0, g_left = 0;
  bit   mon_on = 1'b0;

  always #4 clk = ~clk;

  rst_supervisor #(.REC_CYC(REC), .WD_CYC(WD), .FILT_CYC(FILT), .ACT_LOW(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .man_rst_ni(man_n),
    .wd_kick_i(kick), .wd_en_i(wd_en), .rst_o(rst_lo));

  rst_supervisor #(.REC_CYC(REC), .WD_CYC(WD), .FILT_CYC(FILT), .ACT_LOW(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .man_rst_ni(man_n),
    .wd_kick_i(kick), .wd_en_i(wd_en), .rst_o(rst_hi));

  function automatic bit asserted();
    return rst_lo === 1'b0;
  endfunction

  // expected edge counts derived from the requirements
  function automatic int exp_release();
    return REC + 2;
  endfunction
  function automatic int exp_kick_timeout();
    return WD + FILT + 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_on && (rst_hi !== ~rst_lo)) pol_bad++;

  task automatic wait_rst(input bit want, input int lim, input bit glitch, output int n);
    n = 0;
    while (asserted() != want && n < lim) begin
      @(negedge clk);
      n++;
      if (glitch) begin
        if (g_left > 0) begin
          g_left--;
          if (g_left == 0) kick = 1'b0;
        end else if ($urandom_range(0, 3) == 0) begin
          kick = 1'b1;
          g_left = $urandom_range(1, FILT - 1);
        end
      end
    end
    kick = 1'b0;
    g_left = 0;
  endtask

  task automatic finish_run();
    chk(pol_bad == 0, "R11 polarity mirror", pol_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int n, w, hits;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(rst_lo === 1'b0, "R5 reset state lo", int'(rst_lo), 0);
    chk(rst_hi === 1'b1, "R11 reset state hi", int'(rst_hi), 1);
    mon_on = 1'b1;
    rst_n = 1'b1;
    wait_rst(1'b0, 500, 1'b0, n);
    chk(n == exp_release(), "R5 power-on release", n, exp_release());

    // supply low
    pwr_ok = 1'b0;
    repeat (3) @(negedge clk);
    chk(asserted(), "R1 supply low asserts", int'(asserted()), 1);
    hits = 0;
    w = $urandom_range(5, 40);
    repeat (w) begin @(negedge clk); if (!asserted()) hits++; end
    chk(hits == 0, "R1 held while low", hits, 0);
    pwr_ok = 1'b1;
    wait_rst(1'b0, 500, 1'b0, n);
    chk(n == exp_release(), "R3 recovery after supply", n, exp_release());

    // manual reset, random widths
    for (int i = 0; i < 4; i++) begin
      man_n = 1'b0;
      w = $urandom_range(3, 30);
      repeat (w) @(negedge clk);
      chk(asserted(), "R2 manual asserts", int'(asserted()), 1);
      man_n = 1'b1;
      wait_rst(1'b0, 500, 1'b0, n);
      chk(n == exp_release(), "R3 recovery after manual", n, exp_release());
    end

    // supply dip inside the recovery window
    for (int i = 0; i < 3; i++) begin
      pwr_ok = 1'b0;
      repeat (4) @(negedge clk);
      pwr_ok = 1'b1;
      w = $urandom_range(3, REC - 1);
      repeat (w) @(negedge clk);
      pwr_ok = 1'b0;
      repeat (2) @(negedge clk);
      pwr_ok = 1'b1;
      wait_rst(1'b0, 500, 1'b0, n);
      chk(n == exp_release(), "R4 dip restarts recovery", n, exp_release());
    end

    // watchdog with only glitches on kick
    wd_en = 1'b1;
    wait_rst(1'b1, 1000, 1'b1, n);
    chk(n == WD, "R6 R9 timeout despite glitches", n, WD);
    for (int i = 0; i < 2; i++) begin
      wait_rst(1'b0, 1000, 1'b0, n);
      chk(n == REC, "R7 stuck kick high time", n, REC);
      wait_rst(1'b1, 1000, 1'b1, n);
      chk(n == WD, "R7 stuck kick low time", n, WD);
    end
    wait_rst(1'b0, 1000, 1'b0, n);
    chk(n == REC, "R6 watchdog reset length", n, REC);

    // valid kicks of both polarities keep reset off
    hits = 0;
    for (int i = 0; i < 10; i++) begin
      kick = ~kick;
      w = $urandom_range(FILT + 3, WD - FILT - 10);
      repeat (w) begin @(negedge clk); if (asserted()) hits++; end
    end
    chk(hits == 0, "R8 kicks hold off reset", hits, 0);
    kick = ~kick;
    n = 0;
    while (!asserted() && n < 1000) begin @(negedge clk); n++; end
    chk(n == exp_kick_timeout(), "R8 timeout after last kick", n, exp_kick_timeout());
    n = 0;
    while (asserted() && n < 1000) begin @(negedge clk); n++; end

    // watchdog disabled
    wd_en = 1'b0;
    hits = 0;
    repeat (3 * WD) begin @(negedge clk); if (asserted()) hits++; end
    chk(hits == 0, "R10 disabled watchdog idle", hits, 0);

    finish_run();
  end
endmodule